// File: doc/BRIEF.md
# Handshaked Frequency Sweep Controller

This block steps a phase-accumulator sine synthesizer through a fixed list of logarithmically spaced frequencies, from 100 Hz up to 100 kHz. It gives the synthesizer a tuning word and an enable. An external microcontroller paces every step with two flags. The first flag tells the block that the controller is ready to capture, and output at the current frequency starts only after this flag. The second flag tells the block that capture has finished, and only then does the block move on.

Status goes back to the controller on four lines. There is a one-cycle pulse when a measurement sequence begins. There is a pair of amplitude-mode lines that name the attenuation setting in force, full or half. There is a sticky flag that is raised once the last frequency has been handled. Both incoming flags are asynchronous. Each one passes through a two-flop synchronizer and is then edge-detected, so a level that stays high causes exactly one transition.

Top module: `freq_sweep_ctrl`

## Requirements
- R1: While reset is low, synth_en_o, init_o and sweep_done_o are 0, amp_full_o is 1, amp_half_o is 0, and tune_word_o holds the word of step 0. With the default 12 MHz clock and a 32-bit accumulator, that word is 35791.
- R2: The tuning word for step i is floor(f_i * 2^ACC_W / CLK_HZ). The frequencies are built as follows: f_0 = F_START, and each next entry is f_{i+1} = floor(f_i * RATIO_NUM / RATIO_DEN). The last step is forced to F_STOP. With the defaults, the last word is 35791394.
- R3: synth_en_o rises on the third rising clock edge after the ready flag goes from 0 to 1, provided the block is waiting for ready. It is still 0 after the second edge.
- R4: After the done flag rises while output is active, synth_en_o falls on the third clock edge. One edge later, tune_word_o shows the next step's word.
- R5: init_o is high for exactly one cycle, on the first clock edge after reset is released.
- R6: Once the done flag of the last step has been handled, sweep_done_o rises on the fourth clock edge after that flag rose. It then stays high until reset, synth_en_o stays 0, and further flag activity changes nothing.
- R7: A flag that is held high causes only one transition. A new step needs a fresh 0-to-1 edge of ready.
- R8: A done edge seen while waiting for ready is ignored. A ready edge seen while output is active is ignored. In both cases the enable and the tuning word are unchanged.
- R9: Steps with an index at or above HALF_FROM_STEP (default 8) report half amplitude (amp_half_o=1, amp_full_o=0). Lower steps report full amplitude. Exactly one of the two lines is high at any time.
- R10: Asserting reset in the middle of a sweep stops output at once and returns the block to step 0. After release, the sequence begins again with a new init pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mcu_ready_i | input | 1 | Controller ready to capture (asynchronous) |
| mcu_done_i | input | 1 | Controller finished capture (asynchronous) |
| tune_word_o | output | ACC_W | Phase increment for the synthesizer |
| synth_en_o | output | 1 | Synthesizer enable |
| init_o | output | 1 | One-cycle pulse at the start of a sequence |
| amp_full_o | output | 1 | Full-amplitude mode in force |
| amp_half_o | output | 1 | Half-amplitude mode in force |
| sweep_done_o | output | 1 | Sticky sweep-complete flag |

## Verification
Each incoming flag passes through two synchronizer flops and one edge flop before the state register, so a flag edge driven at a falling clock edge shows up on the enable after exactly three rising edges. The step index and the sweep-done flag settle one edge after that. The init pulse appears on the first edge after reset is released. The bench drives every input just after a falling edge and counts rising edges up to the exact cycle of each result. It checks the output one edge early, where the old value must still hold, and again at the due cycle, always sampling at the falling edge.

// File: rtl/sweep_pkg.sv
package sweep_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_INIT,
        ST_WAIT_RDY,
        ST_GEN,
        ST_WAIT_DONE,
        ST_NEXT,
        ST_FINISH
    } sweep_state_e;

    // Frequency of step idx in Hz: geometric chain from f_start, last entry pinned.
    function automatic longint unsigned step_freq(
        input int unsigned       idx,
        input int unsigned       steps,
        input longint unsigned   f_start,
        input longint unsigned   f_stop,
        input longint unsigned   r_num,
        input longint unsigned   r_den
    );
        longint unsigned f;
        f = f_start;
        for (int unsigned k = 0; k < idx; k++) begin
            f = (f * r_num) / r_den;
        end
        if (idx == steps - 1) begin
            f = f_stop;
        end
        return f;
    endfunction

    // Phase increment for a given output frequency.
    function automatic longint unsigned freq_to_word(
        input longint unsigned f_hz,
        input int unsigned     acc_w,
        input longint unsigned clk_hz
    );
        return (f_hz << acc_w) / clk_hz;
    endfunction

endpackage

// File: rtl/sweep_edge_sync.sv
module sweep_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic async_i,
    output logic rise_o
);

    logic [STAGES:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-1:0], async_i};
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            chain_q <= '0;
        end else begin
            chain_q <= chain_d;
        end
    end

    // chain_q[STAGES-1] is the synchronized level, chain_q[STAGES] its delayed copy
    assign rise_o = chain_q[STAGES-1] & ~chain_q[STAGES];

endmodule

// File: rtl/sweep_tune_rom.sv
module sweep_tune_rom
    import sweep_pkg::*;
#(
    parameter int              STEPS     = 16,
    parameter int              ACC_W     = 32,
    parameter longint unsigned CLK_HZ    = 64'd12_000_000,
    parameter longint unsigned F_START   = 64'd100,
    parameter longint unsigned F_STOP    = 64'd100_000,
    parameter longint unsigned RATIO_NUM = 64'd1585,
    parameter longint unsigned RATIO_DEN = 64'd1000,
    localparam int             IDX_W     = $clog2(STEPS)
) (
    input  logic [IDX_W-1:0] idx_i,
    output logic [ACC_W-1:0] word_o
);

    logic [ACC_W-1:0] words [STEPS];

    for (genvar g = 0; g < STEPS; g++) begin : g_entry
        localparam longint unsigned FREQ = step_freq(g, STEPS, F_START, F_STOP,
                                                     RATIO_NUM, RATIO_DEN);
        localparam longint unsigned WORD = freq_to_word(FREQ, ACC_W, CLK_HZ);
        assign words[g] = ACC_W'(WORD);
    end

    assign word_o = words[idx_i];

endmodule

// File: rtl/sweep_fsm.sv
module sweep_fsm
    import sweep_pkg::*;
#(
    parameter int  STEPS          = 16,
    parameter int  HALF_FROM_STEP = 8,
    localparam int IDX_W          = $clog2(STEPS)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             ready_rise_i,
    input  logic             done_rise_i,
    output logic [IDX_W-1:0] step_o,
    output logic             synth_en_o,
    output logic             init_o,
    output logic             amp_full_o,
    output logic             amp_half_o,
    output logic             sweep_done_o
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(STEPS - 1);
    localparam logic [IDX_W-1:0] HALF_IDX = IDX_W'(HALF_FROM_STEP);

    typedef struct packed {
        sweep_state_e     state;
        logic [IDX_W-1:0] step;
        logic             en;
        logic             init;
        logic             full;
        logic             half;
        logic             fin;
    } fsm_regs_t;

    localparam fsm_regs_t RESET_VAL = '{
        state: ST_IDLE,
        step:  '0,
        en:    1'b0,
        init:  1'b0,
        full:  (HALF_FROM_STEP != 0),
        half:  (HALF_FROM_STEP == 0),
        fin:   1'b0
    };

    fsm_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        unique case (r_q.state)
            ST_IDLE: begin
                r_d.state = ST_INIT;
            end
            ST_INIT: begin
                r_d.step  = '0;
                r_d.state = ST_WAIT_RDY;
            end
            ST_WAIT_RDY: begin
                if (ready_rise_i) begin
                    r_d.state = ST_GEN;
                end
            end
            ST_GEN: begin
                r_d.state = ST_WAIT_DONE;
            end
            ST_WAIT_DONE: begin
                if (done_rise_i) begin
                    r_d.state = ST_NEXT;
                end
            end
            ST_NEXT: begin
                if (r_q.step == LAST_IDX) begin
                    r_d.state = ST_FINISH;
                end else begin
                    r_d.step  = r_q.step + 1'b1;
                    r_d.state = ST_WAIT_RDY;
                end
            end
            ST_FINISH: begin
                r_d.state = ST_FINISH;
            end
            default: begin
                r_d.state = ST_IDLE;
            end
        endcase

        // Registered outputs follow the next state
        r_d.en   = (r_d.state == ST_GEN) || (r_d.state == ST_WAIT_DONE);
        r_d.init = (r_d.state == ST_INIT);
        r_d.fin  = (r_d.state == ST_FINISH);
        r_d.half = (r_d.step >= HALF_IDX);
        r_d.full = (r_d.step <  HALF_IDX);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            r_q <= RESET_VAL;
        end else begin
            r_q <= r_d;
        end
    end

    assign step_o       = r_q.step;
    assign synth_en_o   = r_q.en;
    assign init_o       = r_q.init;
    assign amp_full_o   = r_q.full;
    assign amp_half_o   = r_q.half;
    assign sweep_done_o = r_q.fin;

endmodule

// File: rtl/freq_sweep_ctrl.sv
module freq_sweep_ctrl #(
    parameter int              STEPS          = 16,
    parameter int              ACC_W          = 32,
    parameter int              SYNC_STAGES    = 2,
    parameter int              HALF_FROM_STEP = 8,
    parameter longint unsigned CLK_HZ         = 64'd12_000_000,
    parameter longint unsigned F_START        = 64'd100,
    parameter longint unsigned F_STOP         = 64'd100_000,
    parameter longint unsigned RATIO_NUM      = 64'd1585,
    parameter longint unsigned RATIO_DEN      = 64'd1000
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             mcu_ready_i,
    input  logic             mcu_done_i,
    output logic [ACC_W-1:0] tune_word_o,
    output logic             synth_en_o,
    output logic             init_o,
    output logic             amp_full_o,
    output logic             amp_half_o,
    output logic             sweep_done_o
);

    localparam int IDX_W   = $clog2(STEPS);
    localparam int N_FLAGS = 2;

    logic [N_FLAGS-1:0] flag_raw;
    logic [N_FLAGS-1:0] flag_rise;
    logic               ready_rise;
    logic               done_rise;
    logic [IDX_W-1:0]   step_idx;

    assign flag_raw = {mcu_done_i, mcu_ready_i};

    for (genvar g = 0; g < N_FLAGS; g++) begin : g_flag
        sweep_edge_sync #(
            .STAGES (SYNC_STAGES)
        ) u_sync (
            .clk_i   (clk_i),
            .rst_ni  (rst_ni),
            .async_i (flag_raw[g]),
            .rise_o  (flag_rise[g])
        );
    end

    assign ready_rise = flag_rise[0];
    assign done_rise  = flag_rise[1];

    sweep_fsm #(
        .STEPS          (STEPS),
        .HALF_FROM_STEP (HALF_FROM_STEP)
    ) u_fsm (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .ready_rise_i (ready_rise),
        .done_rise_i  (done_rise),
        .step_o       (step_idx),
        .synth_en_o   (synth_en_o),
        .init_o       (init_o),
        .amp_full_o   (amp_full_o),
        .amp_half_o   (amp_half_o),
        .sweep_done_o (sweep_done_o)
    );

    sweep_tune_rom #(
        .STEPS     (STEPS),
        .ACC_W     (ACC_W),
        .CLK_HZ    (CLK_HZ),
        .F_START   (F_START),
        .F_STOP    (F_STOP),
        .RATIO_NUM (RATIO_NUM),
        .RATIO_DEN (RATIO_DEN)
    ) u_rom (
        .idx_i  (step_idx),
        .word_o (tune_word_o)
    );

endmodule

// File: rtl/freq_sweep_chk.sv
module freq_sweep_chk #(
    parameter int  STEPS = 16,
    parameter int  ACC_W = 32,
    localparam int IDX_W = $clog2(STEPS)
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             ready_rise_i,
    input logic             done_rise_i,
    input logic [IDX_W-1:0] step_i,
    input logic [ACC_W-1:0] tune_i,
    input logic             synth_en_i,
    input logic             init_i,
    input logic             amp_full_i,
    input logic             amp_half_i,
    input logic             sweep_done_i
);

    // R3: output only starts after a synchronized ready edge
    a_r3_en_after_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(synth_en_i) |-> $past(ready_rise_i));

    // R4: output only stops after a synchronized done edge
    a_r4_stop_after_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(synth_en_i) |-> $past(done_rise_i));

    // R4: the step index only moves forward by one, or restarts at zero
    a_r4_step_advance: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(step_i) |-> ((step_i == '0) || (step_i == $past(step_i) + 1'b1)));

    // R4: the step never changes while the synthesizer runs
    a_r4_step_idle_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(step_i) |-> !synth_en_i);

    // R2: tuning word holds steady while output is active
    a_r2_word_steady: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (synth_en_i && $past(synth_en_i)) |-> $stable(tune_i));

    // R5: init is a single-cycle pulse
    a_r5_init_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
        init_i |=> !init_i);

    // R6: done is sticky and excludes output
    a_r6_done_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sweep_done_i |=> sweep_done_i);

    a_r6_done_no_en: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sweep_done_i |-> !synth_en_i);

    // R9: exactly one amplitude mode line is high
    a_r9_one_mode: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $countones({amp_full_i, amp_half_i}) == 1);

endmodule

bind freq_sweep_ctrl freq_sweep_chk #(
    .STEPS (STEPS),
    .ACC_W (ACC_W)
) u_chk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .ready_rise_i (ready_rise),
    .done_rise_i  (done_rise),
    .step_i       (step_idx),
    .tune_i       (tune_word_o),
    .synth_en_i   (synth_en_o),
    .init_i       (init_o),
    .amp_full_i   (amp_full_o),
    .amp_half_i   (amp_half_o),
    .sweep_done_i (sweep_done_o)
);

// File: tb/sim_freq_sweep_ctrl.sv
`timescale 1ns/1ps
module sim_freq_sweep_ctrl;

    localparam int              STEPS  = 16;
    localparam int              ACC_W  = 32;
    localparam int              HALF_AT = 8;
    localparam longint unsigned CLK_HZ = 64'd12_000_000;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             ready = 1'b0;
    logic             done = 1'b0;
    logic [ACC_W-1:0] tune;
    logic             en, init, full, half, fin;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    freq_sweep_ctrl u0 (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .mcu_ready_i  (ready),
        .mcu_done_i   (done),
        .tune_word_o  (tune),
        .synth_en_o   (en),
        .init_o       (init),
        .amp_full_o   (full),
        .amp_half_o   (half),
        .sweep_done_o (fin)
    );

    // R2: expected word from the stated recipe
    function automatic longint unsigned exp_word(input int i);
        longint unsigned f = 64'd100;
        for (int k = 0; k < i; k++) f = (f * 64'd1585) / 64'd1000;
        if (i == STEPS - 1) f = 64'd100_000;
        return (f << ACC_W) / CLK_HZ;
    endfunction

    task automatic chk(input string req, input longint unsigned act, input longint unsigned exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset(input string req);
        @(negedge clk);
        rst_n = 1'b0; ready = 1'b0; done = 1'b0;
        cyc(2);
        chk({req, " R1 en"}, en, 0);
        chk({req, " R1 init"}, init, 0);
        chk({req, " R1 done"}, fin, 0);
        chk({req, " R1 full"}, full, 1);
        chk({req, " R1 half"}, half, 0);
        chk({req, " R1 word0"}, tune, 64'd35791);
        rst_n = 1'b1;
        cyc(1);
        chk({req, " R5 init high"}, init, 1);
        cyc(1);
        chk({req, " R5 init low"}, init, 0);
        chk({req, " R5 en low"}, en, 0);
    endtask

    // One sweep step; hold keeps ready high (R7), ooo adds a stray ready edge (R8)
    task automatic do_step(input int i, input bit hold, input bit ooo);
        ready = 1'b1;
        cyc(2);
        chk($sformatf("R3 en early step %0d", i), en, 0);
        cyc(1);
        chk($sformatf("R3 en step %0d", i), en, 1);
        chk($sformatf("R2 word step %0d", i), tune, exp_word(i));
        chk($sformatf("R9 half step %0d", i), half, (i >= HALF_AT) ? 1 : 0);
        chk($sformatf("R9 full step %0d", i), full, (i >= HALF_AT) ? 0 : 1);
        if (!hold) ready = 1'b0;
        if (ooo) begin
            cyc(3);
            ready = 1'b1;
            cyc(4);
            chk("R8 en after stray ready", en, 1);
            chk("R8 word after stray ready", tune, exp_word(i));
            ready = 1'b0;
            cyc(3);
        end
        done = 1'b1;
        cyc(2);
        chk($sformatf("R4 en still on step %0d", i), en, 1);
        cyc(1);
        chk($sformatf("R4 en off step %0d", i), en, 0);
        done = 1'b0;
        cyc(1);
        if (i == STEPS - 1) begin
            chk("R6 sweep done", fin, 1);
        end else begin
            chk($sformatf("R4 next word after %0d", i), tune, exp_word(i + 1));
            chk($sformatf("R6 not done at %0d", i), fin, 0);
        end
        if (hold) begin
            cyc(5);
            chk("R7 held ready no new step", en, 0);
            ready = 1'b0;
            cyc(3);
        end
    endtask

    task automatic t_done_early(input int i);
        done = 1'b1;
        cyc(5);
        chk("R8 en after early done", en, 0);
        chk("R8 word after early done", tune, exp_word(i));
        chk("R8 fin after early done", fin, 0);
        done = 1'b0;
        cyc(3);
    endtask

    task automatic t_after_finish;
        ready = 1'b1;
        cyc(4);
        chk("R6 en stays off", en, 0);
        chk("R6 done sticky", fin, 1);
        ready = 1'b0;
        done = 1'b1;
        cyc(4);
        chk("R6 done sticky after flag", fin, 1);
        chk("R6 en off after flag", en, 0);
        chk("R2 last word", tune, 64'd35791394);
        chk("R9 half at end", half, 1);
        done = 1'b0;
        cyc(3);
    endtask

    task automatic t_mid_reset;
        t_reset("R10");
        do_step(0, 1'b0, 1'b0);
        do_step(1, 1'b0, 1'b0);
        ready = 1'b1;
        cyc(3);
        chk("R10 running before reset", en, 1);
        rst_n = 1'b0;
        ready = 1'b0;
        cyc(1);
        chk("R10 en off in reset", en, 0);
        chk("R10 word back to 0", tune, exp_word(0));
        chk("R10 full in reset", full, 1);
        chk("R10 done off in reset", fin, 0);
        rst_n = 1'b1;
        cyc(1);
        chk("R10 init again", init, 1);
        cyc(1);
        do_step(0, 1'b0, 1'b0);
    endtask

    initial begin
        t_reset("start");
        do_step(0, 1'b0, 1'b0);
        do_step(1, 1'b1, 1'b0);
        t_done_early(2);
        do_step(2, 1'b0, 1'b0);
        do_step(3, 1'b0, 1'b1);
        for (int i = 4; i < STEPS; i++) do_step(i, 1'b0, 1'b0);
        t_after_finish();
        t_mid_reset();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule